// File: doc/BRIEF.md
# Debug Core Register Transfer Port

This block gives an external debugger access to a single processor register at a time while the core sits in debug halt. The debugger sees three words on a small 32-bit register bus: a status word, a selector and a data word. It programs the selector with a register code and a direction. That write alone launches the transfer. The block turns the code into a register-file index and moves one word across a request/acknowledge port to the core. When the core answers, the block raises a ready flag.

Register codes are sparse. Codes 0 to 12 reach the general registers. Code 14 is the link register, 15 the debug return address, 16 the program status word, 17 the main stack pointer and 18 the process stack pointer. Code 13 is an alias for whichever stack pointer the core has active. Code 20 carries the two control bits and the interrupt priority mask, packed into one debugger word. Every other code finishes at once and leaves all state alone. A transfer only goes to the core while the core reports that it is halted. Until then the request waits.

Top module: `dbgxfer_port`

## Requirements
- R1: After reset the ready flag is 0, the selector and data words read 0, and `core_req` is low.
- R2: Bus layout. Offset 0xC0 is read-only status with the ready flag in bit 16 and all other bits 0. Offset 0xC4 is the selector: the code is in bits 4:0 and the direction is in bit 16 (0 = core to data word, 1 = data word to core). Offset 0xC8 is a 32-bit read/write data word. Any other offset reads 0.
- R3: A selector write accepted while idle clears the ready flag in the next cycle. The flag returns to 1 in the cycle after the edge where `core_req` and `core_ack` are both high.
- R4: `core_req` is raised only while `core_halted` is high. A transfer started while the core runs stays pending, with ready low, until the core halts.
- R5: In the read direction, `core_we` is 0 and the data word takes `core_rdata` at the acknowledging edge.
- R6: In the write direction, `core_we` is 1, `core_wdata` carries the data word, and the data word itself is left unchanged.
- R7: Codes 0 to 12 and 14 to 18 appear unchanged on `core_idx`.
- R8: Code 13 appears on `core_idx` as 17 when `core_sp_sel` is 0 and as 18 when it is 1. Index 13 never appears on the core port.
- R9: Code 20 uses index 20. The core-side word carries control in bits 2:1 and the priority mask in bit 0. In the debugger word, control sits in bits 25:24 and the mask in bit 0. On a read, every other bit of the data word becomes 0. On a write, bits 31:3 of `core_wdata` are 0.
- R10: Codes 19 and 21 to 31 raise no `core_req`. Ready returns to 1 one cycle after the flag is cleared. A read loads 0 into the data word, and a write leaves it unchanged.
- R11: While a transfer is in flight, bus writes to the selector and to the data word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W (8) | Register bus byte offset |
| bus_wdata | input | DATA_W (32) | Register bus write data |
| bus_rdata | output | DATA_W (32) | Register bus read data, decoded from `bus_addr` |
| core_halted | input | 1 | Core is in debug halt |
| core_sp_sel | input | 1 | Active stack pointer: 0 main, 1 process |
| core_req | output | 1 | Transfer request to the register file |
| core_we | output | 1 | Request direction: 1 writes the core register |
| core_idx | output | 5 | Register-file index of the request |
| core_wdata | output | DATA_W (32) | Write data toward the core |
| core_rdata | input | DATA_W (32) | Read data from the core, valid with `core_ack` |
| core_ack | input | 1 | Register file has completed the request |

## Verification
The bench covers the stack-pointer alias under both selector settings. A design that passed index 13 straight through, or chose the wrong pointer, would return the other pointer's value. It packs and unpacks the control/mask word with junk in the unused bits. A design that skipped the masking would leak those bits into the core or the data word. Unlisted codes are checked for an immediate finish with no request and a zeroed read. A design that forwarded them would hang or corrupt the register file. The bench also starts a transfer while the core runs and writes into a busy port. A design that ignored the halt gate, or let a second selector write retarget a live request, would show the wrong index or data.

// File: rtl/dbgxfer_pkg.sv
package dbgxfer_pkg;

   localparam int unsigned CODE_W = 5;

   localparam logic [CODE_W-1:0] CODE_SP_ALIAS = 5'd13;
   localparam logic [CODE_W-1:0] CODE_MSP      = 5'd17;
   localparam logic [CODE_W-1:0] CODE_PSP      = 5'd18;
   localparam logic [CODE_W-1:0] CODE_SPECIAL  = 5'd20;

   // placement of the packed special word on the debugger side
   localparam int unsigned CTRL_LSB  = 24;
   localparam int unsigned CTRL_W    = 2;
   localparam int unsigned PMASK_BIT = 0;

   typedef enum logic {
      XF_IDLE = 1'b0,
      XF_BUSY = 1'b1
   } xfer_state_e;

   typedef struct packed {
      logic              dir;
      logic [CODE_W-1:0] code;
   } sel_t;

   function automatic logic code_listed(input logic [CODE_W-1:0] c);
      return (c <= CODE_PSP) || (c == CODE_SPECIAL);
   endfunction

endpackage

// File: rtl/dbgxfer_decode.sv
module dbgxfer_decode
   import dbgxfer_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   input  logic              sp_sel,
   output logic [CODE_W-1:0] idx,
   output logic              listed,
   output logic              special
);

   always_comb begin
      listed  = code_listed(code);
      special = (code == CODE_SPECIAL);
      if (code == CODE_SP_ALIAS) begin
         idx = sp_sel ? CODE_PSP : CODE_MSP;
      end else begin
         idx = code;
      end
   end

endmodule

// File: rtl/dbgxfer_pack.sv
module dbgxfer_pack
   import dbgxfer_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter bit          PACK_SPECIAL = 1'b1
) (
   input  logic              special,
   input  logic [DATA_W-1:0] dbg_data,
   input  logic [DATA_W-1:0] core_data,
   output logic [DATA_W-1:0] to_core,
   output logic [DATA_W-1:0] from_core
);

   generate
      if (PACK_SPECIAL) begin : g_packed
         logic [DATA_W-1:0] pk_out;
         logic [DATA_W-1:0] pk_in;

         always_comb begin
            pk_out                     = '0;
            pk_out[CTRL_W:1]           = dbg_data[CTRL_LSB +: CTRL_W];
            pk_out[0]                  = dbg_data[PMASK_BIT];
            pk_in                      = '0;
            pk_in[CTRL_LSB +: CTRL_W]  = core_data[CTRL_W:1];
            pk_in[PMASK_BIT]           = core_data[0];
         end

         assign to_core   = special ? pk_out : dbg_data;
         assign from_core = special ? pk_in  : core_data;
      end else begin : g_raw
         logic unused_special;
         assign unused_special = special;
         assign to_core   = dbg_data;
         assign from_core = core_data;
      end
   endgenerate

endmodule

// File: rtl/dbgxfer_ctrl.sv
module dbgxfer_ctrl
   import dbgxfer_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DIR_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wdata,
   input  logic              listed,
   input  logic              core_halted,
   input  logic              core_ack,
   input  logic [DATA_W-1:0] load_val,
   output logic              core_req,
   output logic              core_we,
   output logic              ready,
   output logic [DATA_W-1:0] data_q,
   output sel_t              sel_q
);

   xfer_state_e state_q;
   logic        done_core;
   logic        done_skip;

   assign core_req  = (state_q == XF_BUSY) && listed && core_halted;
   assign core_we   = sel_q.dir;
   assign done_core = core_req && core_ack;
   assign done_skip = (state_q == XF_BUSY) && !listed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         ready   <= 1'b0;
         data_q  <= '0;
         sel_q   <= '0;
      end else if (state_q == XF_IDLE) begin
         if (wr_sel) begin
            sel_q.code <= wdata[CODE_W-1:0];
            sel_q.dir  <= wdata[DIR_BIT];
            state_q    <= XF_BUSY;
            ready      <= 1'b0;
         end else if (wr_data) begin
            data_q <= wdata;
         end
      end else begin
         if (done_skip) begin
            state_q <= XF_IDLE;
            ready   <= 1'b1;
            if (!sel_q.dir) begin
               data_q <= '0;
            end
         end else if (done_core) begin
            state_q <= XF_IDLE;
            ready   <= 1'b1;
            if (!sel_q.dir) begin
               data_q <= load_val;
            end
         end
      end
   end

endmodule

// File: rtl/dbgxfer_regif.sv
module dbgxfer_regif
   import dbgxfer_pkg::*;
#(
   parameter int unsigned     ADDR_W    = 8,
   parameter int unsigned     DATA_W    = 32,
   parameter int unsigned     DIR_BIT   = 16,
   parameter int unsigned     READY_BIT = 16,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'hC0,
   parameter logic [ADDR_W-1:0] OFS_SEL  = 'hC4,
   parameter logic [ADDR_W-1:0] OFS_DATA = 'hC8
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              ready,
   input  sel_t              sel_q,
   input  logic [DATA_W-1:0] data_q,
   output logic              wr_sel,
   output logic              wr_data,
   output logic [DATA_W-1:0] bus_rdata
);

   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] sel_word;

   always_comb begin
      stat_word              = '0;
      stat_word[READY_BIT]   = ready;
      sel_word               = '0;
      sel_word[CODE_W-1:0]   = sel_q.code;
      sel_word[DIR_BIT]      = sel_q.dir;
   end

   assign wr_sel  = bus_wr && (bus_addr == OFS_SEL);
   assign wr_data = bus_wr && (bus_addr == OFS_DATA);

   always_comb begin
      unique case (bus_addr)
         OFS_STAT: bus_rdata = stat_word;
         OFS_SEL:  bus_rdata = sel_word;
         OFS_DATA: bus_rdata = data_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dbgxfer_port.sv
module dbgxfer_port
   import dbgxfer_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 8,
   parameter int unsigned       DATA_W       = 32,
   parameter int unsigned       DIR_BIT      = 16,
   parameter int unsigned       READY_BIT    = 16,
   parameter bit                PACK_SPECIAL = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_STAT     = 'hC0,
   parameter logic [ADDR_W-1:0] OFS_SEL      = 'hC4,
   parameter logic [ADDR_W-1:0] OFS_DATA     = 'hC8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_halted,
   input  logic              core_sp_sel,
   output logic              core_req,
   output logic              core_we,
   output logic [4:0]        core_idx,
   output logic [DATA_W-1:0] core_wdata,
   input  logic [DATA_W-1:0] core_rdata,
   input  logic              core_ack
);

   localparam int unsigned MIN_DATA_W = PACK_SPECIAL ? (CTRL_LSB + CTRL_W) : CODE_W;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("dbgxfer_port: DATA_W too narrow for the selected packing");
      end
      if (DIR_BIT < CODE_W || DIR_BIT >= DATA_W) begin : g_bad_dir
         $error("dbgxfer_port: DIR_BIT must sit above the code field and inside DATA_W");
      end
      if (READY_BIT >= DATA_W) begin : g_bad_ready
         $error("dbgxfer_port: READY_BIT outside the data word");
      end
      if (OFS_STAT == OFS_SEL || OFS_SEL == OFS_DATA || OFS_STAT == OFS_DATA) begin : g_bad_ofs
         $error("dbgxfer_port: register offsets must differ");
      end
   endgenerate

   logic              wr_sel;
   logic              wr_data;
   logic              xfer_ready;
   logic [DATA_W-1:0] data_q;
   sel_t              sel_q;
   logic              listed;
   logic              special;
   logic [DATA_W-1:0] load_val;

   dbgxfer_regif #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DIR_BIT   (DIR_BIT),
      .READY_BIT (READY_BIT),
      .OFS_STAT  (OFS_STAT),
      .OFS_SEL   (OFS_SEL),
      .OFS_DATA  (OFS_DATA)
   ) u_regif (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .ready     (xfer_ready),
      .sel_q     (sel_q),
      .data_q    (data_q),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .bus_rdata (bus_rdata)
   );

   dbgxfer_decode u_decode (
      .code    (sel_q.code),
      .sp_sel  (core_sp_sel),
      .idx     (core_idx),
      .listed  (listed),
      .special (special)
   );

   dbgxfer_pack #(
      .DATA_W       (DATA_W),
      .PACK_SPECIAL (PACK_SPECIAL)
   ) u_pack (
      .special   (special),
      .dbg_data  (data_q),
      .core_data (core_rdata),
      .to_core   (core_wdata),
      .from_core (load_val)
   );

   dbgxfer_ctrl #(
      .DATA_W  (DATA_W),
      .DIR_BIT (DIR_BIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .wdata       (bus_wdata),
      .listed      (listed),
      .core_halted (core_halted),
      .core_ack    (core_ack),
      .load_val    (load_val),
      .core_req    (core_req),
      .core_we     (core_we),
      .ready       (xfer_ready),
      .data_q      (data_q),
      .sel_q       (sel_q)
   );

endmodule

// File: rtl/dbgxfer_port_chk.sv
module dbgxfer_port_chk
   import dbgxfer_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] OFS_SEL = 'hC4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              core_halted,
   input logic              core_req,
   input logic              core_we,
   input logic [4:0]        core_idx,
   input logic              core_ack,
   input logic              xfer_ready
);

   p_req_only_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> core_halted);

   p_ready_low_in_flight_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> !xfer_ready);

   p_sel_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ready && bus_wr && bus_addr == OFS_SEL) |=> !xfer_ready);

   p_ack_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && core_ack) |=> xfer_ready);

   p_no_alias_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> (core_idx != CODE_SP_ALIAS));

   p_no_unlisted_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> (core_idx <= CODE_PSP || core_idx == CODE_SPECIAL));

   p_dir_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && !core_ack) |=> (!core_req || $stable(core_we)));

endmodule

bind dbgxfer_port dbgxfer_port_chk #(
   .ADDR_W  (ADDR_W),
   .OFS_SEL (OFS_SEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .core_halted (core_halted),
   .core_req    (core_req),
   .core_we     (core_we),
   .core_idx    (core_idx),
   .core_ack    (core_ack),
   .xfer_ready  (xfer_ready)
);

// File: tb/dbgxfer_port_tb.sv
module dbgxfer_port_tb;

   localparam logic [7:0] A_STAT = 8'hC0;
   localparam logic [7:0] A_SEL  = 8'hC4;
   localparam logic [7:0] A_DATA = 8'hC8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        core_halted = 1'b1;
   logic        core_sp_sel = 1'b0;
   logic        core_req;
   logic        core_we;
   logic [4:0]  core_idx;
   logic [31:0] core_wdata;
   logic [31:0] core_rdata = '0;
   logic        core_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // register-file model driven by the responder
   logic [31:0] mdl [32];
   int          lat = 1;
   int          acks = 0;
   logic [4:0]  last_idx = '0;
   logic        last_we = 1'b0;
   logic [31:0] last_wdata = '0;

   always #10 clk = ~clk;

   dbgxfer_port u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .core_halted (core_halted),
      .core_sp_sel (core_sp_sel),
      .core_req    (core_req),
      .core_we     (core_we),
      .core_idx    (core_idx),
      .core_wdata  (core_wdata),
      .core_rdata  (core_rdata),
      .core_ack    (core_ack)
   );

   // responder: acknowledges after lat waiting cycles
   initial begin : responder
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (core_req) begin
            core_rdata = mdl[core_idx];
            if (cnt >= lat) begin
               core_ack   = 1'b1;
               last_idx   = core_idx;
               last_we    = core_we;
               last_wdata = core_wdata;
               acks++;
               cnt = 0;
            end else begin
               core_ack = 1'b0;
               cnt++;
            end
         end else begin
            core_ack = 1'b0;
            cnt = 0;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_ready(input string tag);
      logic [31:0] s;
      bit          seen;
      seen = 1'b0;
      for (int i = 0; i < 60 && !seen; i++) begin
         bus_read(A_STAT, s);
         seen = s[16];
      end
      check({tag, " ready reached"}, {31'd0, seen}, 32'd1);
   endtask

   function automatic logic [31:0] sel_word(input bit dir, input logic [4:0] code);
      return {15'd0, dir, 11'd0, code};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      bus_read(A_STAT, v); check("R1 status after reset", v, 32'd0);
      bus_read(A_SEL, v);  check("R1 selector after reset", v, 32'd0);
      bus_read(A_DATA, v); check("R1 data after reset", v, 32'd0);
      check("R1 no request after reset", {31'd0, core_req}, 32'd0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      bus_write(A_DATA, 32'hA5A5_5A5A);
      bus_read(A_DATA, v); check("R2 data word read/write", v, 32'hA5A5_5A5A);
      bus_read(8'hD0, v);  check("R2 unused offset reads zero", v, 32'd0);
      bus_read(A_STAT, v); check("R2 status idle", v, 32'd0);
   endtask

   task automatic t_read_codes();
      logic [31:0] v;
      logic [4:0]  codes [8] = '{5'd0, 5'd5, 5'd12, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18};
      lat = 2;
      foreach (codes[k]) begin
         bus_write(A_SEL, sel_word(1'b0, codes[k]));
         peek(A_STAT, v); check("R3 ready cleared by selector write", v, 32'd0);
         wait_ready("R3 read");
         bus_read(A_DATA, v);   check("R5 read loads core value", v, mdl[codes[k]]);
         check("R7 index passes through", {27'd0, last_idx}, {27'd0, codes[k]});
         check("R5 read direction", {31'd0, last_we}, 32'd0);
      end
      bus_read(A_SEL, v); check("R2 selector readback", v, sel_word(1'b0, 5'd18));
   endtask

   task automatic t_write_gpr();
      logic [31:0] v;
      lat = 0;
      bus_write(A_DATA, 32'h1357_9BDF);
      bus_write(A_SEL, sel_word(1'b1, 5'd3));
      wait_ready("R6 write");
      check("R6 write direction", {31'd0, last_we}, 32'd1);
      check("R6 write data to core", last_wdata, 32'h1357_9BDF);
      check("R7 write index", {27'd0, last_idx}, 32'd3);
      bus_read(A_DATA, v); check("R6 data word unchanged", v, 32'h1357_9BDF);
   endtask

   task automatic t_alias();
      logic [31:0] v;
      lat = 1;
      core_sp_sel = 1'b0;
      bus_write(A_SEL, sel_word(1'b0, 5'd13));
      wait_ready("R8 alias main");
      check("R8 alias to main pointer index", {27'd0, last_idx}, 32'd17);
      bus_read(A_DATA, v); check("R8 alias main value", v, mdl[17]);
      core_sp_sel = 1'b1;
      bus_write(A_SEL, sel_word(1'b0, 5'd13));
      wait_ready("R8 alias process");
      check("R8 alias to process pointer index", {27'd0, last_idx}, 32'd18);
      bus_read(A_DATA, v); check("R8 alias process value", v, mdl[18]);
      core_sp_sel = 1'b0;
   endtask

   task automatic t_special();
      logic [31:0] v;
      lat = 1;
      mdl[20] = 32'hFFFF_FFF5;   // junk above bit 2; ctrl=2'b10, mask=1
      bus_write(A_SEL, sel_word(1'b0, 5'd20));
      wait_ready("R9 special read");
      bus_read(A_DATA, v); check("R9 special unpacked", v, 32'h0200_0001);
      check("R9 special index", {27'd0, last_idx}, 32'd20);
      bus_write(A_DATA, 32'h51F0_F0F0);  // ctrl bits 25:24 = 01, mask 0
      bus_write(A_SEL, sel_word(1'b1, 5'd20));
      wait_ready("R9 special write");
      check("R9 special packed to core", last_wdata, 32'h0000_0002);
   endtask

   task automatic t_unlisted();
      logic [31:0] v;
      logic [4:0]  codes [3] = '{5'd19, 5'd21, 5'd31};
      int          a0;
      foreach (codes[k]) begin
         bus_write(A_DATA, 32'h0000_DEAD);
         a0 = acks;
         bus_write(A_SEL, sel_word(1'b0, codes[k]));
         peek(A_STAT, v);     check("R10 ready cleared", v, 32'd0);
         bus_read(A_STAT, v); check("R10 ready one cycle later", v, 32'h0001_0000);
         bus_read(A_DATA, v); check("R10 unlisted read gives zero", v, 32'd0);
         check("R10 no core request", acks, a0);
      end
      bus_write(A_DATA, 32'h0000_BEEF);
      a0 = acks;
      bus_write(A_SEL, sel_word(1'b1, 5'd25));
      wait_ready("R10 unlisted write");
      bus_read(A_DATA, v); check("R10 unlisted write keeps data", v, 32'h0000_BEEF);
      check("R10 no core request on write", acks, a0);
   endtask

   task automatic t_halt_gate();
      logic [31:0] v;
      bit          req_seen;
      lat = 0;
      core_halted = 1'b0;
      bus_write(A_SEL, sel_word(1'b0, 5'd2));
      req_seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (core_req) req_seen = 1'b1;
      end
      check("R4 no request while running", {31'd0, req_seen}, 32'd0);
      bus_read(A_STAT, v); check("R4 still pending", v, 32'd0);
      core_halted = 1'b1;
      wait_ready("R4 after halt");
      bus_read(A_DATA, v); check("R4 value after halt", v, mdl[2]);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      lat = 6;
      bus_write(A_SEL, sel_word(1'b0, 5'd4));
      bus_write(A_DATA, 32'h0000_1234);
      bus_write(A_SEL, sel_word(1'b1, 5'd7));
      wait_ready("R11 busy");
      check("R11 index not retargeted", {27'd0, last_idx}, 32'd4);
      check("R11 direction not retargeted", {31'd0, last_we}, 32'd0);
      bus_read(A_DATA, v); check("R11 data write dropped", v, mdl[4]);
      bus_read(A_SEL, v);  check("R11 selector write dropped", v, sel_word(1'b0, 5'd4));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 32; i++) mdl[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0003;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_read_codes();
      t_write_gpr();
      t_alias();
      t_special();
      t_unlisted();
      t_halt_gate();
      t_busy_ignore();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule